// File: doc/BRIEF.md
# ISA Slave Address Decode and Byte-Lane Steering

This block sits behind the I/O-bus pins of a peripheral that hangs on a PC-style ISA slot. It decides whether the current I/O cycle belongs to the peripheral by comparing the upper address bits against five base-address straps, gated by the active-low address enable. It then works out which of the two byte lanes of the 16-bit data bus carries the access. The lane choice depends on the host-width strap, the byte-high enable and the low address bit. One address pairs both lanes onto the two FIFOs.

Selected bytes go to a 32-entry byte register space or to one of two byte FIFOs (A and B). Reads drive the chosen lanes, and the block reports which lanes it drives so the pad ring can enable them. Writes commit on the rising edge of the write strobe. The block also raises the 16-bit cycle indication for upper-lane accesses and inserts a short not-ready window at the start of FIFO accesses. Open-collector pins are modelled as active-high "pull low" enables. All bus inputs are treated as already synchronous to `clk`.

Top module: `isa_slave_steer`

## Requirements
- R1: The block is selected only while `aen_n` is 0 and `addr[9:5]` equals `base_strap`. When it is not selected, no lane is driven, nothing is written or popped, and `rdy_low` and `cs16_low` stay 0.
- R2: Each strap bit at 0 matches address bit 0 and each strap bit at 1 matches address bit 1. Straps `10110` decode the window 0x2C0 to 0x2DF. Changing the straps moves the window.
- R3: On a 16-bit host (`host8`=0) with `bhe_n`=0 and `addr[4:0]`=0x18, the upper lane reads or writes FIFO A and the lower lane reads or writes FIFO B in the same cycle.
- R4: On a 16-bit host with `bhe_n`=0 at an odd address, only the upper lane is used. The lower lane is not driven on reads and its byte is ignored on writes.
- R5: With `bhe_n`=1, an even address on a 16-bit host uses only the lower lane. With `bhe_n`=1, any address on an 8-bit host (`host8`=1) uses only the lower lane.
- R6: The byte reached depends only on `addr[4:0]`. 0x18 is FIFO B, 0x19 is FIFO A, and every other value is the register with that index. The same register is reached whichever lane carries it.
- R7: `cs16_low` is 1 whenever the block is selected with a lane plan that uses the upper lane. No strobe is needed for this.
- R8: A write commits when `iow_n` rises. It uses the address and data last present while `iow_n` was low. Data changed after the rising edge has no effect.
- R9: A legal selected access to address 0x18 or 0x19 holds `rdy_low` at 1 for the first `WAIT_CYCLES` (default 2) cycles of its strobe and then releases it. Register accesses never pull it.
- R10: Three combinations are illegal while selected: an 8-bit host with `bhe_n`=0, a 16-bit host with `bhe_n`=0 at an even address other than 0x18, and a 16-bit host with `bhe_n`=1 at an odd address. An illegal access drives no lane and writes or pops nothing.
- R11: FIFOs are first-in first-out with `FIFO_DEPTH` (default 4) entries. A read pops on the rising edge of `ior_n`. An empty FIFO reads as 0 and is not popped. A write to a full FIFO is dropped.
- R12: After reset all registers read 0, both FIFOs are empty, and all outputs are 0 while idle. Undriven lanes of `rd_data` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 10 | I/O address |
| aen_n | input | 1 | Active-low address enable |
| bhe_n | input | 1 | Active-low byte-high enable |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| host8 | input | 1 | Host-width strap, 1 = 8-bit host, 0 = 16-bit host |
| base_strap | input | 5 | Base-address straps compared against addr[9:5] |
| wr_data | input | 16 | Write data, upper lane in [15:8] |
| rd_data | output | 16 | Read data, zero on undriven lanes |
| lo_oe | output | 1 | Drive enable for the lower lane |
| hi_oe | output | 1 | Drive enable for the upper lane |
| cs16_low | output | 1 | Pull-low enable for the 16-bit cycle indication |
| rdy_low | output | 1 | Pull-low enable for the ready line |
| chip_sel | output | 1 | Window decode hit |

## Verification
The hardest case to reach from the ports is the paired FIFO access that follows single-byte traffic on both FIFOs. Its outcome depends on data pushed earlier through two other lane plans. The stimulus first fills A and B with paired writes, then drains them with single-lane reads at 0x19 on an 8-bit host and at 0x18 with the byte-high enable released. This shows that each FIFO advances independently. Overflow of one FIFO is reached by pushing one byte more than the depth through the lower lane and draining past empty. Illegal lane combinations are driven as writes and then read back through legal plans, so that a stray write would show up at the ports.

// File: rtl/isa_steer_pkg.sv
package isa_steer_pkg;

   // Which byte lanes a decoded access uses.
   typedef enum logic [1:0] {
      PLAN_NONE = 2'd0,
      PLAN_LO   = 2'd1,
      PLAN_HI   = 2'd2,
      PLAN_PAIR = 2'd3
   } lane_plan_e;

   function automatic logic plan_single(input lane_plan_e p);
      return (p == PLAN_LO) || (p == PLAN_HI);
   endfunction

   function automatic logic plan_uses_hi(input lane_plan_e p);
      return (p == PLAN_HI) || (p == PLAN_PAIR);
   endfunction

   function automatic logic plan_uses_lo(input lane_plan_e p);
      return (p == PLAN_LO) || (p == PLAN_PAIR);
   endfunction

endpackage

// File: rtl/isa_window_match.sv
module isa_window_match #(
   parameter int ADDR_W = 10,
   parameter int BASE_W = 5
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BASE_W-1:0] base_strap,
   input  logic              aen_n,
   output logic              hit
);
   localparam int LSB = ADDR_W - BASE_W;

   logic [BASE_W-1:0] bit_eq;

   // One comparator per strap bit: a 0 strap expects a 0 address bit.
   for (genvar i = 0; i < BASE_W; i++) begin : g_cmp
      assign bit_eq[i] = ~(addr[LSB+i] ^ base_strap[i]);
   end

   assign hit = (&bit_eq) & ~aen_n;

endmodule

// File: rtl/isa_lane_plan.sv
module isa_lane_plan
   import isa_steer_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter int PAIR_ADDR = 24
) (
   input  logic              host8,
   input  logic              bhe_n,
   input  logic [REG_AW-1:0] reg_addr,
   output lane_plan_e        plan
);
   localparam logic [REG_AW-1:0] ADDR_B = PAIR_ADDR[REG_AW-1:0];

   always_comb begin
      plan = PLAN_NONE;
      if (host8) begin
         // Narrow host: lower lane only, high enable must be released.
         if (bhe_n) plan = PLAN_LO;
      end else if (!bhe_n) begin
         if (reg_addr == ADDR_B)  plan = PLAN_PAIR;
         else if (reg_addr[0])    plan = PLAN_HI;
      end else if (!reg_addr[0]) begin
         plan = PLAN_LO;
      end
   end

endmodule

// File: rtl/isa_fifo.sv
module isa_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam logic [PTR_W:0] FULL_CNT = (PTR_W + 1)'(DEPTH);

   if (DEPTH < 2) begin : g_bad_small
      $error("isa_fifo: DEPTH must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("isa_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W:0]   count;
   logic             empty, full, do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

endmodule

// File: rtl/isa_byte_space.sv
module isa_byte_space
   import isa_steer_pkg::*;
#(
   parameter int REG_AW     = 5,
   parameter int PAIR_ADDR  = 24,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  lane_plan_e        rd_plan,
   input  logic [REG_AW-1:0] rd_addr,
   input  logic              wr_en,
   input  lane_plan_e        wr_plan,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              pop_en,
   input  lane_plan_e        pop_plan,
   input  logic [REG_AW-1:0] pop_addr,
   output logic [7:0]        rd_hi,
   output logic [7:0]        rd_lo
);
   localparam int REG_N = 1 << REG_AW;
   localparam logic [REG_AW-1:0] ADDR_B = PAIR_ADDR[REG_AW-1:0];
   localparam logic [REG_AW-1:0] ADDR_A = ADDR_B | REG_AW'(1);

   logic [7:0] regs [REG_N];
   logic [1:0] push, pop;
   logic [7:0] push_d [2];
   logic [7:0] head   [2];
   logic [7:0] w_single, rd_single;
   logic       wr_to_fifo;

   // Index 0 is FIFO A (upper lane of a pair), index 1 is FIFO B.
   always_comb begin
      w_single   = (wr_plan == PLAN_HI) ? wr_data[15:8] : wr_data[7:0];
      wr_to_fifo = (wr_addr == ADDR_A) || (wr_addr == ADDR_B);

      push[0]   = wr_en & ((wr_plan == PLAN_PAIR) |
                           (plan_single(wr_plan) & (wr_addr == ADDR_A)));
      push[1]   = wr_en & ((wr_plan == PLAN_PAIR) |
                           (plan_single(wr_plan) & (wr_addr == ADDR_B)));
      push_d[0] = (wr_plan == PLAN_PAIR) ? wr_data[15:8] : w_single;
      push_d[1] = (wr_plan == PLAN_PAIR) ? wr_data[7:0]  : w_single;

      pop[0] = pop_en & ((pop_plan == PLAN_PAIR) |
                         (plan_single(pop_plan) & (pop_addr == ADDR_A)));
      pop[1] = pop_en & ((pop_plan == PLAN_PAIR) |
                         (plan_single(pop_plan) & (pop_addr == ADDR_B)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_N; i++) regs[i] <= '0;
      end else if (wr_en && plan_single(wr_plan) && !wr_to_fifo) begin
         regs[wr_addr] <= w_single;
      end
   end

   for (genvar k = 0; k < 2; k++) begin : g_fifo
      isa_fifo #(
         .W     (8),
         .DEPTH (FIFO_DEPTH)
      ) u_fifo (
         .clk   (clk),
         .rst_n (rst_n),
         .push  (push[k]),
         .pop   (pop[k]),
         .wdata (push_d[k]),
         .rdata (head[k])
      );
   end

   always_comb begin
      if (rd_addr == ADDR_A)      rd_single = head[0];
      else if (rd_addr == ADDR_B) rd_single = head[1];
      else                        rd_single = regs[rd_addr];

      unique case (rd_plan)
         PLAN_PAIR: begin rd_hi = head[0];   rd_lo = head[1];   end
         PLAN_HI:   begin rd_hi = rd_single; rd_lo = '0;        end
         PLAN_LO:   begin rd_hi = '0;        rd_lo = rd_single; end
         default:   begin rd_hi = '0;        rd_lo = '0;        end
      endcase
   end

endmodule

// File: rtl/isa_wait_gen.sv
module isa_wait_gen #(
   parameter int WAIT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic need_wait,
   output logic rdy_low
);
   if (WAIT_CYCLES == 0) begin : g_nowait
      assign rdy_low = 1'b0;
      logic unused_in;
      assign unused_in = &{clk, rst_n, active, need_wait};
   end else begin : g_wait
      localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
      localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYCLES);

      logic [CNT_W-1:0] cnt;

      // Counts strobe cycles of the current access, saturating at LIMIT.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (!active)    cnt <= '0;
         else if (cnt < LIMIT) cnt <= cnt + 1'b1;
      end

      assign rdy_low = active & need_wait & (cnt < LIMIT);
   end

endmodule

// File: rtl/isa_slave_steer.sv
module isa_slave_steer
   import isa_steer_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int BASE_W      = 5,
   parameter int REG_AW      = 5,
   parameter int PAIR_ADDR   = 24,
   parameter int FIFO_DEPTH  = 4,
   parameter int WAIT_CYCLES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              aen_n,
   input  logic              bhe_n,
   input  logic              ior_n,
   input  logic              iow_n,
   input  logic              host8,
   input  logic [BASE_W-1:0] base_strap,
   input  logic [15:0]       wr_data,
   output logic [15:0]       rd_data,
   output logic              lo_oe,
   output logic              hi_oe,
   output logic              cs16_low,
   output logic              rdy_low,
   output logic              chip_sel
);
   if (ADDR_W != BASE_W + REG_AW) begin : g_bad_split
      $error("isa_slave_steer: ADDR_W must equal BASE_W + REG_AW");
   end
   if ((PAIR_ADDR % 2) != 0 || PAIR_ADDR >= (1 << REG_AW)) begin : g_bad_pair
      $error("isa_slave_steer: PAIR_ADDR must be even and inside the register space");
   end

   localparam logic [REG_AW-2:0] FIFO_HI_BITS = PAIR_ADDR[REG_AW-1:1];

   logic [REG_AW-1:0] reg_addr;
   lane_plan_e        plan;
   logic              hit, legal, rd_act, need_wait, strobe_act;
   logic [7:0]        rd_hi, rd_lo;

   logic              iow_q, ior_q;
   logic              wcap_valid, rcap_valid;
   lane_plan_e        wcap_plan, rcap_plan;
   logic [REG_AW-1:0] wcap_addr, rcap_addr;
   logic [15:0]       wcap_data;
   logic              wr_commit, rd_commit;

   assign reg_addr = addr[REG_AW-1:0];

   isa_window_match #(
      .ADDR_W (ADDR_W),
      .BASE_W (BASE_W)
   ) u_match (
      .addr       (addr),
      .base_strap (base_strap),
      .aen_n      (aen_n),
      .hit        (hit)
   );

   isa_lane_plan #(
      .REG_AW    (REG_AW),
      .PAIR_ADDR (PAIR_ADDR)
   ) u_plan (
      .host8    (host8),
      .bhe_n    (bhe_n),
      .reg_addr (reg_addr),
      .plan     (plan)
   );

   assign legal    = (plan != PLAN_NONE);
   assign rd_act   = hit & legal & ~ior_n;
   assign lo_oe    = rd_act & plan_uses_lo(plan);
   assign hi_oe    = rd_act & plan_uses_hi(plan);
   assign cs16_low = hit & plan_uses_hi(plan);
   assign chip_sel = hit;
   assign rd_data  = {hi_oe ? rd_hi : 8'h00, lo_oe ? rd_lo : 8'h00};

   // Capture the cycle while each strobe is low; commit on its rising edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iow_q      <= 1'b1;
         ior_q      <= 1'b1;
         wcap_valid <= 1'b0;
         rcap_valid <= 1'b0;
         wcap_plan  <= PLAN_NONE;
         rcap_plan  <= PLAN_NONE;
         wcap_addr  <= '0;
         rcap_addr  <= '0;
         wcap_data  <= '0;
      end else begin
         iow_q <= iow_n;
         ior_q <= ior_n;
         if (!iow_n) begin
            wcap_valid <= hit & legal;
            wcap_plan  <= plan;
            wcap_addr  <= reg_addr;
            wcap_data  <= wr_data;
         end else begin
            wcap_valid <= 1'b0;
         end
         if (!ior_n) begin
            rcap_valid <= hit & legal;
            rcap_plan  <= plan;
            rcap_addr  <= reg_addr;
         end else begin
            rcap_valid <= 1'b0;
         end
      end
   end

   assign wr_commit = iow_n & ~iow_q & wcap_valid;
   assign rd_commit = ior_n & ~ior_q & rcap_valid;

   isa_byte_space #(
      .REG_AW     (REG_AW),
      .PAIR_ADDR  (PAIR_ADDR),
      .FIFO_DEPTH (FIFO_DEPTH)
   ) u_space (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_plan  (plan),
      .rd_addr  (reg_addr),
      .wr_en    (wr_commit),
      .wr_plan  (wcap_plan),
      .wr_addr  (wcap_addr),
      .wr_data  (wcap_data),
      .pop_en   (rd_commit),
      .pop_plan (rcap_plan),
      .pop_addr (rcap_addr),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo)
   );

   assign strobe_act = hit & (~ior_n | ~iow_n);
   assign need_wait  = legal & (reg_addr[REG_AW-1:1] == FIFO_HI_BITS);

   isa_wait_gen #(
      .WAIT_CYCLES (WAIT_CYCLES)
   ) u_wait (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (strobe_act),
      .need_wait (need_wait),
      .rdy_low   (rdy_low)
   );

endmodule

// File: rtl/isa_slave_steer_chk.sv
module isa_slave_steer_chk #(
   parameter int ADDR_W      = 10,
   parameter int WAIT_CYCLES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              aen_n,
   input logic              bhe_n,
   input logic              ior_n,
   input logic              host8,
   input logic              lo_oe,
   input logic              hi_oe,
   input logic              cs16_low,
   input logic              rdy_low,
   input logic              chip_sel
);
   int unsigned low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_run <= 0;
      else if (rdy_low) low_run <= low_run + 1;
      else              low_run <= 0;
   end

   assert_oe_needs_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_oe || hi_oe) |-> (!aen_n && chip_sel && !ior_n));

   assert_narrow_lo_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host8 && bhe_n) |-> (!hi_oe && !cs16_low));

   assert_odd_no_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!host8 && !bhe_n && addr[0]) |-> !lo_oe);

   assert_hi_has_cs16_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hi_oe |-> cs16_low);

   assert_illegal_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (host8 && !bhe_n) |-> (!lo_oe && !hi_oe && !cs16_low));

   assert_rdy_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_sel |-> !rdy_low);

   assert_rdy_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rdy_low |-> (low_run < WAIT_CYCLES));

endmodule

bind isa_slave_steer isa_slave_steer_chk #(
   .ADDR_W      (ADDR_W),
   .WAIT_CYCLES (WAIT_CYCLES)
) u_chk (.*);

// File: tb/isa_slave_steer_bench.sv
module isa_slave_steer_bench;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  addr = '0;
   logic        aen_n = 1'b1, bhe_n = 1'b1, ior_n = 1'b1, iow_n = 1'b1;
   logic        host8 = 1'b0;
   logic [4:0]  strap = 5'b10110;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        lo_oe, hi_oe, cs16_low, rdy_low, chip_sel;

   always #5 clk = ~clk;

   isa_slave_steer u_isa_slave_steer (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (addr),
      .aen_n      (aen_n),
      .bhe_n      (bhe_n),
      .ior_n      (ior_n),
      .iow_n      (iow_n),
      .host8      (host8),
      .base_strap (strap),
      .wr_data    (wr_data),
      .rd_data    (rd_data),
      .lo_oe      (lo_oe),
      .hi_oe      (hi_oe),
      .cs16_low   (cs16_low),
      .rdy_low    (rdy_low),
      .chip_sel   (chip_sel)
   );

   typedef struct {
      logic        lo;
      logic        hi;
      logic        cs16;
      logic        rdy;
      logic [15:0] data;
      string       tag;
   } exp_t;

   exp_t       exp_q [$];
   logic [7:0] regs [32];
   logic [7:0] qa [$];
   logic [7:0] qb [$];
   int         n_cmp = 0;
   int         n_bad = 0;
   logic       mon_req = 1'b0;
   logic       done = 1'b0;

   // Lane plan from R3, R4, R5, R10: 0 none, 1 lower, 2 upper, 3 pair.
   function automatic int mplan(input logic h8, input logic bhe, input logic [4:0] a);
      if (h8) return bhe ? 1 : 0;
      if (!bhe) begin
         if (a == 5'h18) return 3;
         return a[0] ? 2 : 0;
      end
      return a[0] ? 0 : 1;
   endfunction

   // Byte reached at an address (R6, R11).
   function automatic logic [7:0] mbyte(input logic [4:0] a);
      if (a == 5'h18) return (qb.size() > 0) ? qb[0] : 8'h00;
      if (a == 5'h19) return (qa.size() > 0) ? qa[0] : 8'h00;
      return regs[a];
   endfunction

   task automatic cmp(input logic [19:0] act, input logic [19:0] expv, input string tag);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s: act lo/hi/cs16/rdy/data=%05h exp=%05h", tag, act, expv);
      end
   endtask

   // Monitor: pops the next expected item whenever the driver asks.
   always @(negedge clk) begin
      if (mon_req) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: no expected item act=%05h exp=none",
                     {lo_oe, hi_oe, cs16_low, rdy_low, rd_data});
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            cmp({lo_oe, hi_oe, cs16_low, rdy_low, rd_data},
                {e.lo, e.hi, e.cs16, e.rdy, e.data}, e.tag);
         end
      end
   end

   task automatic access(input logic wr, input logic [9:0] a, input logic bhe,
                         input logic h8, input logic aen, input logic [15:0] wd,
                         input string tag);
      exp_t       e;
      logic       sel, legal;
      int         p;
      logic [7:0] sb;
      sel   = !aen && (a[9:5] == strap);
      p     = mplan(h8, bhe, a[4:0]);
      legal = (p != 0);
      e.lo = 1'b0; e.hi = 1'b0; e.data = 16'h0000;
      e.cs16 = sel && (p >= 2);
      if (!wr && sel && legal) begin
         if (p == 3) begin
            e.lo = 1'b1; e.hi = 1'b1;
            e.data = {mbyte(5'h19), mbyte(5'h18)};
         end else begin
            sb = mbyte(a[4:0]);
            if (p == 2) begin e.hi = 1'b1; e.data = {sb, 8'h00}; end
            else        begin e.lo = 1'b1; e.data = {8'h00, sb}; end
         end
      end
      e.rdy = sel && legal && (a[4:1] == 4'hC);
      e.tag = tag;

      @(posedge clk); #1;
      addr = a; bhe_n = bhe; host8 = h8; aen_n = aen; wr_data = wd;
      if (wr) iow_n = 1'b0; else ior_n = 1'b0;
      exp_q.push_back(e); mon_req = 1'b1;
      @(posedge clk); #1;
      mon_req = 1'b0;
      @(posedge clk); #1;
      e.rdy = 1'b0;
      exp_q.push_back(e); mon_req = 1'b1;
      @(posedge clk); #1;
      mon_req = 1'b0; iow_n = 1'b1; ior_n = 1'b1; wr_data = 16'hDEAD;
      @(posedge clk); #1;
      aen_n = 1'b1; addr = '0; bhe_n = 1'b1;

      if (sel && legal) begin
         if (wr) begin
            if (p == 3) begin
               if (qa.size() < DEPTH) qa.push_back(wd[15:8]);
               if (qb.size() < DEPTH) qb.push_back(wd[7:0]);
            end else begin
               sb = (p == 2) ? wd[15:8] : wd[7:0];
               if (a[4:0] == 5'h18)      begin if (qb.size() < DEPTH) qb.push_back(sb); end
               else if (a[4:0] == 5'h19) begin if (qa.size() < DEPTH) qa.push_back(sb); end
               else regs[a[4:0]] = sb;
            end
         end else begin
            if (p == 3) begin
               if (qa.size() > 0) void'(qa.pop_front());
               if (qb.size() > 0) void'(qb.pop_front());
            end else if (a[4:0] == 5'h18) begin
               if (qb.size() > 0) void'(qb.pop_front());
            end else if (a[4:0] == 5'h19) begin
               if (qa.size() > 0) void'(qa.pop_front());
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R12: idle outputs after reset
      cmp({lo_oe, hi_oe, cs16_low, rdy_low, rd_data}, 20'h0, "R12 idle after reset");
      n_cmp++;
      if (chip_sel !== 1'b0) begin n_bad++; $display("FAIL R12 chip_sel act=%b exp=0", chip_sel); end

      access(0, 10'h2C4, 1, 0, 0, 16'h0, "R12 register reads zero");
      access(0, 10'h2D8, 1, 0, 0, 16'h0, "R12 FIFO B empty reads zero");

      // R5 / R2: lower lane in window 0x2C0
      access(1, 10'h2C4, 1, 0, 0, 16'h775A, "R5 write even lower lane");
      access(0, 10'h2C4, 1, 0, 0, 16'h0, "R5 read even lower lane");
      access(0, 10'h2DF, 1, 1, 0, 16'h0, "R2 top of window selected");

      // R4: odd address upper lane, lower byte ignored
      access(1, 10'h2C5, 0, 0, 0, 16'hA733, "R4 write odd upper lane");
      access(0, 10'h2C5, 0, 0, 0, 16'h0, "R4 read odd upper lane only");
      access(0, 10'h2C4, 1, 0, 0, 16'h0, "R4 lower byte ignored on odd write");
      // R6: same register through the lower lane of a narrow host
      access(0, 10'h2C5, 1, 1, 0, 16'h0, "R6 same register via narrow host");

      // R8: data captured while strobe low, later change ignored
      access(1, 10'h2C6, 1, 1, 0, 16'h0042, "R8 write latch at rise");
      access(0, 10'h2C6, 1, 1, 0, 16'h0, "R8 read back latched data");

      // R1: address enable high or window miss
      access(1, 10'h2C7, 1, 1, 1, 16'h0099, "R1 write with aen_n high");
      access(0, 10'h2C7, 1, 1, 1, 16'h0, "R1 read with aen_n high");
      access(1, 10'h2E7, 1, 1, 0, 16'h0066, "R1 write outside window");
      access(0, 10'h2A7, 1, 1, 0, 16'h0, "R1 read outside window");
      access(0, 10'h2C7, 1, 1, 0, 16'h0, "R1 register untouched");

      // R2: move the window to base 0
      strap = 5'b00000;
      access(1, 10'h00A, 1, 0, 0, 16'h00C3, "R2 write at base 0");
      access(0, 10'h00A, 1, 0, 0, 16'h0, "R2 read at base 0");
      access(0, 10'h2CA, 1, 0, 0, 16'h0, "R2 old window deselected");
      strap = 5'b10110;
      access(0, 10'h2CA, 1, 0, 0, 16'h0, "R2 restored window");

      // R10: illegal combinations write nothing, drive nothing
      access(1, 10'h2C8, 0, 1, 0, 16'h1111, "R10 narrow host with bhe write");
      access(1, 10'h2CC, 0, 0, 0, 16'h2222, "R10 wide even bhe write");
      access(1, 10'h2C9, 1, 0, 0, 16'h3333, "R10 wide odd no-bhe write");
      access(0, 10'h2C9, 1, 0, 0, 16'h0, "R10 illegal read drives nothing");
      access(0, 10'h2C8, 1, 1, 0, 16'h0, "R10 reg 08 still zero");
      access(0, 10'h2CC, 1, 1, 0, 16'h0, "R10 reg 0C still zero");
      access(0, 10'h2C9, 1, 1, 0, 16'h0, "R10 reg 09 still zero");

      // R3: paired FIFO access, R7 and R9 checked in every item
      access(1, 10'h2D8, 0, 0, 0, 16'h1122, "R3 pair write first");
      access(1, 10'h2D8, 0, 0, 0, 16'h3344, "R3 pair write second");
      access(0, 10'h2D8, 0, 0, 0, 16'h0, "R3 pair read");
      access(0, 10'h2D9, 1, 1, 0, 16'h0, "R6 single read FIFO A");
      access(0, 10'h2D8, 1, 0, 0, 16'h0, "R6 single read FIFO B");
      access(0, 10'h2D8, 0, 0, 0, 16'h0, "R11 pair read both empty");
      access(1, 10'h2D9, 0, 0, 0, 16'h5500, "R9 upper lane FIFO A write");
      access(0, 10'h2D9, 0, 0, 0, 16'h0, "R9 upper lane FIFO A read");

      // R11: overflow of FIFO B through the lower lane
      for (int i = 1; i <= DEPTH + 1; i++)
         access(1, 10'h2D8, 1, 1, 0, 16'(i), "R11 fill FIFO B");
      for (int i = 0; i <= DEPTH; i++)
         access(0, 10'h2D8, 1, 1, 0, 16'h0, "R11 drain FIFO B");

      repeat (3) @(posedge clk);
      if (exp_q.size() != 0) begin
         n_cmp++; n_bad++;
         $display("FAIL scoreboard leftover act=%0d exp=0", exp_q.size());
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule